// File: doc/BRIEF.md
# Stacked Dual-Flash Chip-Select Steering

This block sits between a SPI/QSPI master engine and two identical serial flash devices. The two devices share one serial clock and one 4-bit data bus, and each has its own active-low chip-select. The engine drives a single logical chip-select. The block expands it into two device selects, so that exactly one device takes part in any one transaction. The data lanes, the lane output enables and the serial clock pass straight through between the engine and the shared bus. Data returned on the bus goes straight back to the engine.

A 32-bit configuration register holds two control bits:

- Bit 30 turns on two-memory mode.
- Bit 28 picks the upper device when two-memory mode is on.

With two-memory mode off, the engine's select goes to the lower device only. The choice of device is fixed when a transaction starts. A register write made while a transaction runs therefore takes effect only once the engine's chip-select has gone high again.

A small state machine does the steering. Its states are:

- `SEL_IDLE`: no transaction is running.
- `SEL_LOWER`: a transaction is running on the lower device.
- `SEL_UPPER`: a transaction is running on the upper device.

Its transitions are:

- `IDLE->LOWER`: the engine's select goes low while the effective target is the lower device.
- `IDLE->UPPER`: the engine's select goes low while two-memory mode and upper-page are both set.
- `LOWER->IDLE` and `UPPER->IDLE`: the engine's select returns high.

In the cycle where the engine's select first goes low, the device select follows the current register value combinationally. From then on it follows the latched state.

Top module: `dflash_cs_steer`

## Requirements
- R1: After reset the configuration reads 0x00000000, the state is idle, and both device selects are high while the engine select is high.
- R2: A write stores bit 30 (two-memory enable) and bit 28 (upper-page). A read returns those two bits in place, and every other bit reads zero.
- R3: With bit 30 clear, a low engine select drives the lower device select low, and the upper device select stays high whatever the value of bit 28.
- R4: With bits 30 and 28 both set when a transaction starts, the upper device select is low and the lower device select is high for the whole transaction.
- R5: With bit 30 set and bit 28 clear when a transaction starts, the lower device select is low and the upper device select is high.
- R6: Whenever the engine select is high, both device selects are high in the same cycle.
- R7: The two device selects are never low in the same cycle.
- R8: The target device is taken from the register value in the cycle the engine select first goes low. A write in that cycle or later changes the target only for the next transaction.
- R9: Bus data-out and the per-lane output enables equal the engine's, the engine's data-in equals the bus data-in, and the device clock equals the engine clock, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write value |
| cfg_rd_data | output | 32 | Configuration read value |
| eng_cs_n | input | 1 | Engine chip-select, active low |
| eng_sclk | input | 1 | Engine serial clock |
| eng_dq_out | input | 4 | Engine data lanes toward the flash |
| eng_dq_oe | input | 4 | Engine per-lane output enables |
| eng_dq_in | output | 4 | Data lanes returned to the engine |
| dev_sclk | output | 1 | Shared serial clock to both devices |
| dev_lo_cs_n | output | 1 | Lower device select, active low |
| dev_hi_cs_n | output | 1 | Upper device select, active low |
| bus_dq_out | output | 4 | Shared bus data driven out |
| bus_dq_oe | output | 4 | Shared bus per-lane output enables |
| bus_dq_in | input | 4 | Shared bus data sampled in |

## Verification
Two functions can fall in the same cycle: a configuration write, and the engine select falling to start a transaction. The bench provokes this in directed cases, and also at random by overlapping random writes with random select bursts. The bench model latches the target from the register value held before the write's clock edge. The device selects are then compared against that model in every cycle of the transaction, and again in the next transaction, where the written value must apply.

// File: rtl/dflash_pkg.sv
package dflash_pkg;
    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_LOWER = 2'd1,
        SEL_UPPER = 2'd2
    } sel_state_t;

    function automatic logic pick_upper(input logic dual_en, input logic upper_page);
        return dual_en & upper_page;
    endfunction
endpackage

// File: rtl/dflash_cfg_reg.sv
module dflash_cfg_reg #(
    parameter int CFG_W    = 32,
    parameter int DUAL_BIT = 30,
    parameter int PAGE_BIT = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             dual_en,
    output logic             upper_page
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_en    <= 1'b0;
            upper_page <= 1'b0;
        end else if (wr_en) begin
            dual_en    <= wr_data[DUAL_BIT];
            upper_page <= wr_data[PAGE_BIT];
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[DUAL_BIT] = dual_en;
        rd_data[PAGE_BIT] = upper_page;
    end

    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[DUAL_BIT] == $past(wr_data[DUAL_BIT])) &&
                  (rd_data[PAGE_BIT] == $past(wr_data[PAGE_BIT])));
endmodule

// File: rtl/dflash_sel_fsm.sv
module dflash_sel_fsm
    import dflash_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eng_cs_n,
    input  logic dual_en,
    input  logic upper_page,
    output logic lo_cs_n,
    output logic hi_cs_n
);
    sel_state_t state_q, state_d;
    logic       want_upper;

    assign want_upper = pick_upper(dual_en, upper_page);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE: begin
                if (!eng_cs_n) state_d = want_upper ? SEL_UPPER : SEL_LOWER;
            end
            SEL_LOWER: begin
                if (eng_cs_n) state_d = SEL_IDLE;
            end
            SEL_UPPER: begin
                if (eng_cs_n) state_d = SEL_IDLE;
            end
            default: state_d = SEL_IDLE;
        endcase
    end

    always_comb begin
        lo_cs_n = 1'b1;
        hi_cs_n = 1'b1;
        unique case (state_q)
            SEL_IDLE: begin
                if (!eng_cs_n) begin
                    hi_cs_n = !want_upper;
                    lo_cs_n = want_upper;
                end
            end
            SEL_LOWER: lo_cs_n = eng_cs_n;
            SEL_UPPER: hi_cs_n = eng_cs_n;
            default: begin
                lo_cs_n = 1'b1;
                hi_cs_n = 1'b1;
            end
        endcase
    end

    // R7
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lo_cs_n && !hi_cs_n));

    // R6
    sel_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cs_n |-> (lo_cs_n && hi_cs_n));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_cs_n && $past(!eng_cs_n) && $past(rst_n)) |-> ($stable(lo_cs_n) && $stable(hi_cs_n)));

    // R3
    single_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_IDLE && !dual_en) |-> hi_cs_n);
endmodule

// File: rtl/dflash_io_path.sv
module dflash_io_path #(
    parameter int DQ_W = 4
) (
    input  logic            eng_sclk,
    input  logic [DQ_W-1:0] eng_dq_out,
    input  logic [DQ_W-1:0] eng_dq_oe,
    output logic [DQ_W-1:0] eng_dq_in,
    output logic            dev_sclk,
    output logic [DQ_W-1:0] bus_dq_out,
    output logic [DQ_W-1:0] bus_dq_oe,
    input  logic [DQ_W-1:0] bus_dq_in
);
    assign dev_sclk = eng_sclk;

    for (genvar g = 0; g < DQ_W; g++) begin : g_lane
        assign bus_dq_out[g] = eng_dq_out[g];
        assign bus_dq_oe[g]  = eng_dq_oe[g];
        assign eng_dq_in[g]  = bus_dq_in[g];
    end
endmodule

// File: rtl/dflash_cs_steer.sv
module dflash_cs_steer #(
    parameter int CFG_W    = 32,
    parameter int DUAL_BIT = 30,
    parameter int PAGE_BIT = 28,
    parameter int DQ_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    input  logic             eng_cs_n,
    input  logic             eng_sclk,
    input  logic [DQ_W-1:0]  eng_dq_out,
    input  logic [DQ_W-1:0]  eng_dq_oe,
    output logic [DQ_W-1:0]  eng_dq_in,
    output logic             dev_sclk,
    output logic             dev_lo_cs_n,
    output logic             dev_hi_cs_n,
    output logic [DQ_W-1:0]  bus_dq_out,
    output logic [DQ_W-1:0]  bus_dq_oe,
    input  logic [DQ_W-1:0]  bus_dq_in
);
    logic dual_en;
    logic upper_page;

    dflash_cfg_reg #(
        .CFG_W(CFG_W), .DUAL_BIT(DUAL_BIT), .PAGE_BIT(PAGE_BIT)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .rd_data(cfg_rd_data),
        .dual_en(dual_en), .upper_page(upper_page)
    );

    dflash_sel_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .eng_cs_n(eng_cs_n),
        .dual_en(dual_en), .upper_page(upper_page),
        .lo_cs_n(dev_lo_cs_n), .hi_cs_n(dev_hi_cs_n)
    );

    dflash_io_path #(.DQ_W(DQ_W)) i_io (
        .eng_sclk(eng_sclk), .eng_dq_out(eng_dq_out), .eng_dq_oe(eng_dq_oe),
        .eng_dq_in(eng_dq_in), .dev_sclk(dev_sclk),
        .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in)
    );

    // R9
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_oe == eng_dq_oe);
endmodule

// File: tb/test_dflash_cs_steer.sv
module test_dflash_cs_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [31:0] cfg_wr_data;
    logic [31:0] cfg_rd_data;
    logic        eng_cs_n, eng_sclk, dev_sclk, dev_lo_cs_n, dev_hi_cs_n;
    logic [3:0]  eng_dq_out, eng_dq_oe, eng_dq_in, bus_dq_out, bus_dq_oe, bus_dq_in;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic m_dual = 1'b0, m_page = 1'b0, m_act = 1'b0, m_hi = 1'b0;

    always #5 clk = ~clk;

    dflash_cs_steer i_dflash_cs_steer (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk),
        .eng_dq_out(eng_dq_out), .eng_dq_oe(eng_dq_oe), .eng_dq_in(eng_dq_in),
        .dev_sclk(dev_sclk), .dev_lo_cs_n(dev_lo_cs_n), .dev_hi_cs_n(dev_hi_cs_n),
        .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic cs_n);
        logic hi;
        if (cs_n) return 2'b11;
        hi = m_act ? m_hi : (m_dual & m_page);
        return hi ? 2'b01 : 2'b10;
    endfunction

    task automatic step(input logic cs_n, input logic wr, input logic [31:0] wd);
        string tag;
        @(negedge clk);
        eng_cs_n    = cs_n;
        cfg_wr_en   = wr;
        cfg_wr_data = wd;
        eng_dq_out  = 4'($urandom);
        eng_dq_oe   = 4'($urandom);
        bus_dq_in   = 4'($urandom);
        eng_sclk    = 1'($urandom);
        #2;
        if (cs_n)              tag = "R6";
        else if (m_act)        tag = "R8";
        else if (!m_dual)      tag = "R3";
        else if (m_page)       tag = "R4";
        else                   tag = "R5";
        chk(tag, {30'b0, dev_hi_cs_n, dev_lo_cs_n}, {30'b0, exp_sel(cs_n)});
        chk("R7", {31'b0, (!dev_hi_cs_n && !dev_lo_cs_n)}, 32'b0);
        chk("R2", cfg_rd_data, {1'b0, m_dual, 1'b0, m_page, 28'b0});
        chk("R9", {19'b0, bus_dq_out, bus_dq_oe, eng_dq_in, dev_sclk},
                  {19'b0, eng_dq_out, eng_dq_oe, bus_dq_in, eng_sclk});
        @(posedge clk);
        #1;
        if (!m_act && !cs_n) begin
            m_act = 1'b1;
            m_hi  = m_dual & m_page;
        end else if (m_act && cs_n) begin
            m_act = 1'b0;
        end
        if (wr) begin
            m_dual = wd[30];
            m_page = wd[28];
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic cs;
        int   run;
        void'($urandom(32'd2024));
        rst_n = 1'b0; eng_cs_n = 1'b1; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        eng_sclk = 1'b0; eng_dq_out = '0; eng_dq_oe = '0; bus_dq_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", cfg_rd_data, 32'h0);
        chk("R1", {30'b0, dev_hi_cs_n, dev_lo_cs_n}, 32'h3);
        rst_n = 1'b1;
        // R1 first transaction after reset goes to lower device
        step(1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b0, 32'h0);
        // R2 only bits 30 and 28 stick
        step(1'b1, 1'b1, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 32'h0);
        // R3 page bit set, dual off: lower used
        step(1'b1, 1'b1, 32'h1000_0000);
        repeat (3) step(1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b0, 32'h0);
        // R5 dual on, page clear, then R8 mid-transfer page set
        step(1'b1, 1'b1, 32'h4000_0000);
        step(1'b0, 1'b0, 32'h0);
        step(1'b0, 1'b1, 32'h5000_0000);
        repeat (2) step(1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b0, 32'h0);
        // R4 next transaction on upper
        repeat (3) step(1'b0, 1'b0, 32'h0);
        // R8 write in the same cycle as the select falls
        step(1'b1, 1'b0, 32'h0);
        step(1'b0, 1'b1, 32'h4000_0000);
        step(1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b0, 32'h0);
        step(1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b0, 32'h0);
        // random mix
        cs  = 1'b1;
        run = 0;
        for (int i = 0; i < 4000; i++) begin
            if (run == 0) begin
                cs  = ~cs;
                run = $urandom_range(1, 8);
            end
            run--;
            step(cs, ($urandom % 5) == 0, $urandom);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule